// File: doc/BRIEF.md
# Clock-Stretching I2C Target Byte Engine

This block is the byte-level half of an I2C target that uses 7-bit addressing. It takes SCL and SDA after they have been synchronized to the system clock. It also takes one-cycle start and stop pulses from a separate bus-condition monitor. It drives open-drain enables for both lines: a 1 on an enable pulls that line low. Incoming bits go into a shift register. After the eighth bit the engine compares the address or accepts the data byte, and then decides whether to acknowledge in the ninth clock. For reads, it shifts a host-supplied byte out on SDA.

Host logic sees a single shared byte buffer, a set of status flags and one event interrupt. To pace the bus, the engine holds SCL low at the end of a byte. The hold lasts until the host strobes the clock-release input. The hold is automatic in the read direction and optional in the write direction.

Top module: `i2c_stretch_slave`

## Requirements
- R1: The first byte after a start is an address byte. Bits [7:1] of that byte are compared with `own_addr`, and bit 0 is latched into `rw_flag` (1 = master reads). On a match the engine pulls SDA low for the ninth clock. It also copies the whole byte into the buffer and clears `data_flag`.
- R2: An address that does not match makes the engine fall silent. It never pulls SDA, raises no flag and no interrupt, and ignores every further byte until the next start.
- R3: If a byte (a matching address or data) completes while `buf_full` or `ovf` is set, no ACK is given and the buffer keeps its old value. In that case `ovf` sets and the engine goes idle. Only `clr_ovf` clears `ovf`.
- R4: `buf_full` is set by a received data byte and by a matching address with bit 0 = 0. It is also set by a buffer write that is accepted during a read. `buf_rd` clears it. In a read, it clears on the eighth SCL falling edge of the byte being sent.
- R5: In the read direction, SCL is held low (`scl_oe` = 1) from the ninth falling edge of the address byte. The same hold follows each transmitted byte that the master ACKs. The hold stays until `release_wr` is strobed.
- R6: In the write direction, `scl_oe` is set after the ninth falling edge of each acknowledged byte only when `stretch_en` = 1; with `stretch_en` = 0 SCL is never held.
- R7: Transmit data leaves MSB first. The first bit appears on SDA when the buffer is written, and each later bit changes on an SCL falling edge.
- R8: The master's ninth-bit level is sampled on the ninth rising edge into `ack_stat` (1 = NACK). `irq` sets on the ninth falling edge of every acknowledged received byte and of every transmitted byte. It stays set until `clr_irq`.
- R9: A master NACK in a read returns the engine to idle without holding SCL and clears `rw_flag`. A stop returns it to idle, releases both lines and clears `rw_flag`. A start also clears `rw_flag`.
- R10: A buffer write during a read, while `buf_full` is set or a byte is in flight, sets `wcol` and leaves the buffer unchanged. Only `clr_wcol` clears `wcol`.
- R11: The engine may see SDA low on an SCL rising edge while it is releasing SDA to send a 1. It then goes idle and stops driving SDA, and `bcol` sets only if `bcol_en` = 1. Only `clr_bcol` clears `bcol`.
- R12: `data_flag` is 0 after an address byte and 1 after a data byte, whether received or transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| start_pulse | input | 1 | One-cycle start/repeated-start pulse from the bus monitor |
| stop_pulse | input | 1 | One-cycle stop pulse from the bus monitor |
| own_addr | input | BYTE_W-1 | 7-bit target address |
| stretch_en | input | 1 | Hold SCL after each received byte |
| bcol_en | input | 1 | Enable the bus-collision flag |
| buf_rd | input | 1 | Host read strobe of the buffer |
| buf_wr | input | 1 | Host write strobe of the buffer |
| buf_wdata | input | BYTE_W | Host write data |
| release_wr | input | 1 | Host strobe that releases SCL |
| clr_ovf | input | 1 | Clear overflow flag |
| clr_wcol | input | 1 | Clear write-collision flag |
| clr_bcol | input | 1 | Clear bus-collision flag |
| clr_irq | input | 1 | Clear event interrupt |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| buf_rdata | output | BYTE_W | Buffer contents |
| buf_full | output | 1 | Buffer holds an unread or unsent byte |
| ovf | output | 1 | Overflow flag |
| wcol | output | 1 | Write-collision flag |
| bcol | output | 1 | Bus-collision flag |
| data_flag | output | 1 | Last byte was data (1) or address (0) |
| rw_flag | output | 1 | Master reads (1) or writes (0) |
| ack_stat | output | 1 | Last master acknowledge, 1 = NACK |
| irq | output | 1 | Sticky event interrupt |

## Verification
The bench builds the engine with `BYTE_W` = 8, the width the I2C byte format requires. With that width the bit counter goes through its full range, including the ninth acknowledge slot, in both directions. The address compare also runs over all seven address bits. The bench acts as master with a wired-AND bus model, so the SCL hold actually stalls its clock. It can therefore check that holds happen, and that they are released, only by the host strobe. Random addresses, data and stretch settings are mixed with directed overflow, write-collision and bus-collision sequences.

// File: rtl/i2cs_pkg.sv
// Shared definitions for the I2C target byte engine.
// Assumes: nothing beyond IEEE 1800-2017.
package i2cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_SEND = 2'd2
    } eng_state_t;

    localparam int FLG_OVF  = 0;
    localparam int FLG_WCOL = 1;
    localparam int FLG_BCOL = 2;
    localparam int FLG_IRQ  = 3;
    localparam int NUM_FLG  = 4;
endpackage

// File: rtl/i2cs_scl_edge.sv
// Detects rising and falling edges of the synchronized SCL level.
// Assumes: scl_in is already synchronized to clk; idle level is high.
module i2cs_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic rise,
    output logic fall
);
    logic scl_q;

    // Remember last SCL level; reset to idle-high so no spurious edge.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_in;
    end

    assign rise = scl_in & ~scl_q;
    assign fall = ~scl_in & scl_q;
endmodule

// File: rtl/i2cs_shreg.sv
// Byte shift register: parallel load, shift-in at LSB, shift-out toward MSB.
// Assumes: at most one of the three controls matters per cycle; load wins.
module i2cs_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_in,
    input  logic         in_bit,
    input  logic         shift_out,
    output logic [W-1:0] q
);
    // Update the shift register according to the active control.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (load)      q <= load_val;
        else if (shift_in)  q <= {q[W-2:0], in_bit};
        else if (shift_out) q <= {q[W-2:0], 1'b0};
    end
endmodule

// File: rtl/i2cs_sticky.sv
// Bank of sticky flags: each sets on its set bit and clears on its clear bit.
// Assumes: set has priority over clear in the same cycle.
module i2cs_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[g] <= 1'b0;
            else if (set[g]) q[g] <= 1'b1;
            else if (clr[g]) q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_stretch_slave.sv
// I2C target byte engine, 7-bit addressing, one shared host byte buffer.
// Receives address/data, decides ACK, transmits host bytes, stretches SCL
// until the host releases it, and keeps the status/interrupt flags.
// Assumes: scl_in/sda_in synchronized; start/stop pulses come from an
// external bus-condition monitor and never coincide with an SCL edge.
module i2c_stretch_slave
    import i2cs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              start_pulse,
    input  logic              stop_pulse,
    input  logic [BYTE_W-2:0] own_addr,
    input  logic              stretch_en,
    input  logic              bcol_en,
    input  logic              buf_rd,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              release_wr,
    input  logic              clr_ovf,
    input  logic              clr_wcol,
    input  logic              clr_bcol,
    input  logic              clr_irq,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_full,
    output logic              ovf,
    output logic              wcol,
    output logic              bcol,
    output logic              data_flag,
    output logic              rw_flag,
    output logic              ack_stat,
    output logic              irq
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    eng_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic              is_addr;
    logic              scl_hold;
    logic [BYTE_W-1:0] buf_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              scl_rise, scl_fall;
    logic [NUM_FLG-1:0] flg_set, flg_clr, flg_q;

    logic quiet, in_recv, in_send, rx_shift, tx_shift, rx_done;
    logic addr_hit, blocked, rx_accept, rx_overflow, ack_end;
    logic tx_load, wr_collide, tx_rise, bus_clash;

    i2cs_scl_edge u_edge (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
        .rise(scl_rise), .fall(scl_fall)
    );

    i2cs_shreg #(.W(BYTE_W)) u_shreg (
        .clk(clk), .rst_n(rst_n),
        .load(tx_load), .load_val(buf_wdata),
        .shift_in(rx_shift), .in_bit(sda_in),
        .shift_out(tx_shift), .q(shreg_q)
    );

    i2cs_sticky #(.N(NUM_FLG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flg_set), .clr(flg_clr), .q(flg_q)
    );

    // Decode the bus and host events of this cycle.
    always_comb begin
        quiet       = !start_pulse && !stop_pulse;
        in_recv     = quiet && (state == ST_RECV);
        in_send     = quiet && (state == ST_SEND);
        rx_shift    = in_recv && scl_rise && (bitcnt < LAST_BIT);
        tx_shift    = in_send && scl_fall && (bitcnt != '0) && (bitcnt < LAST_BIT);
        rx_done     = in_recv && scl_fall && (bitcnt == LAST_BIT);
        addr_hit    = (shreg_q[BYTE_W-1:1] == own_addr);
        blocked     = buf_full || flg_q[FLG_OVF];
        rx_accept   = rx_done && (!is_addr || addr_hit) && !blocked;
        rx_overflow = rx_done && (!is_addr || addr_hit) && blocked;
        ack_end     = (in_recv || in_send) && scl_fall && (bitcnt == ACK_BIT);
        tx_load     = in_send && buf_wr && !buf_full && (bitcnt == '0);
        wr_collide  = in_send && buf_wr && (buf_full || (bitcnt != '0));
        tx_rise     = in_send && scl_rise && (bitcnt < LAST_BIT);
        bus_clash   = tx_rise && !sda_oe && !sda_in;
        flg_set     = '0;
        flg_set[FLG_OVF]  = rx_overflow;
        flg_set[FLG_WCOL] = wr_collide;
        flg_set[FLG_BCOL] = bus_clash && bcol_en;
        flg_set[FLG_IRQ]  = ack_end;
        flg_clr     = '0;
        flg_clr[FLG_OVF]  = clr_ovf;
        flg_clr[FLG_WCOL] = clr_wcol;
        flg_clr[FLG_BCOL] = clr_bcol;
        flg_clr[FLG_IRQ]  = clr_irq;
    end

    // Byte engine: state, bit counter, buffer, line drivers and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            is_addr   <= 1'b0;
            scl_hold  <= 1'b0;
            sda_oe    <= 1'b0;
            buf_q     <= '0;
            buf_full  <= 1'b0;
            data_flag <= 1'b0;
            rw_flag   <= 1'b0;
            ack_stat  <= 1'b0;
        end else begin
            if (buf_rd)     buf_full <= 1'b0;
            if (release_wr) scl_hold <= 1'b0;
            if (start_pulse) begin
                state    <= ST_RECV;
                bitcnt   <= '0;
                is_addr  <= 1'b1;
                rw_flag  <= 1'b0;
                sda_oe   <= 1'b0;
                scl_hold <= 1'b0;
            end else if (stop_pulse) begin
                state    <= ST_IDLE;
                rw_flag  <= 1'b0;
                sda_oe   <= 1'b0;
                scl_hold <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (scl_rise && bitcnt != ACK_BIT) bitcnt <= bitcnt + 1'b1;
                        if (rx_done) begin
                            if (rx_accept) begin
                                sda_oe    <= 1'b1;
                                buf_q     <= shreg_q;
                                data_flag <= !is_addr;
                                if (is_addr) begin
                                    rw_flag  <= shreg_q[0];
                                    buf_full <= !shreg_q[0];
                                end else begin
                                    buf_full <= 1'b1;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        if (ack_end) begin
                            sda_oe  <= 1'b0;
                            bitcnt  <= '0;
                            is_addr <= 1'b0;
                            if (rw_flag) begin
                                state    <= ST_SEND;
                                scl_hold <= 1'b1;
                            end else begin
                                scl_hold <= stretch_en;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise && bitcnt != ACK_BIT) bitcnt <= bitcnt + 1'b1;
                        if (scl_rise && bitcnt == LAST_BIT) ack_stat <= sda_in;
                        if (tx_load) begin
                            buf_q    <= buf_wdata;
                            buf_full <= 1'b1;
                            sda_oe   <= !buf_wdata[BYTE_W-1];
                        end
                        if (tx_shift) sda_oe <= !shreg_q[BYTE_W-2];
                        if (scl_fall && bitcnt == LAST_BIT) begin
                            sda_oe   <= 1'b0;
                            buf_full <= 1'b0;
                        end
                        if (bus_clash) begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end
                        if (ack_end) begin
                            bitcnt    <= '0;
                            data_flag <= 1'b1;
                            if (ack_stat) begin
                                state   <= ST_IDLE;
                                rw_flag <= 1'b0;
                            end else begin
                                scl_hold <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_oe    = scl_hold;
    assign buf_rdata = buf_q;
    assign ovf       = flg_q[FLG_OVF];
    assign wcol      = flg_q[FLG_WCOL];
    assign bcol      = flg_q[FLG_BCOL];
    assign irq       = flg_q[FLG_IRQ];
endmodule

// File: rtl/i2cs_checker.sv
// Temporal checks for the I2C target byte engine, bound to its top.
// Assumes: synchronous active-low reset; properties are off during reset.
module i2cs_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_pulse,
    input logic              stop_pulse,
    input logic              release_wr,
    input logic              scl_fall,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              rw_flag,
    input logic              irq,
    input logic              ovf,
    input logic              wcol,
    input logic [BYTE_W-1:0] buf_rdata
);
    // R9: a start leaves the direction bit cleared.
    p_start_clears_rw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !rw_flag);

    // R9: a stop frees both bus lines.
    p_stop_frees_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> (!scl_oe && !sda_oe));

    // R5: an SCL hold persists until the host release or a bus condition.
    p_hold_until_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !release_wr && !start_pulse && !stop_pulse) |=> scl_oe);

    // R8: the interrupt only rises right after an SCL falling edge.
    p_irq_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(scl_fall));

    // R3: an overflow never comes with an acknowledge being driven.
    p_no_ack_on_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> !sda_oe);

    // R10: a rejected write leaves the buffer contents alone.
    p_wcol_keeps_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $stable(buf_rdata));
endmodule

bind i2c_stretch_slave i2cs_checker #(.BYTE_W(BYTE_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .release_wr(release_wr), .scl_fall(scl_fall), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rw_flag(rw_flag), .irq(irq), .ovf(ovf), .wcol(wcol), .buf_rdata(buf_rdata)
);

// File: tb/i2c_stretch_slave_bench.sv
// Self-checking bench: bench acts as bus master (wired-AND model) and host.
module i2c_stretch_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic start_pulse = 0, stop_pulse = 0, stretch_en = 0, bcol_en = 0;
    logic buf_rd = 0, buf_wr = 0, release_wr = 0;
    logic clr_ovf = 0, clr_wcol = 0, clr_bcol = 0, clr_irq = 0;
    logic [7:0] buf_wdata = '0;
    logic scl_in, sda_in, scl_oe, sda_oe, buf_full, ovf, wcol, bcol;
    logic data_flag, rw_flag, ack_stat, irq;
    logic [7:0] buf_rdata;
    int n_checks = 0, n_fail = 0, sda_drv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign scl_in = m_scl & ~scl_oe;
    assign sda_in = m_sda & ~sda_oe;
    always @(posedge clk) if (sda_oe) sda_drv <= sda_drv + 1;

    i2c_stretch_slave #(.BYTE_W(8)) u_i2c_stretch_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .own_addr(OWN),
        .stretch_en(stretch_en), .bcol_en(bcol_en), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .release_wr(release_wr), .clr_ovf(clr_ovf),
        .clr_wcol(clr_wcol), .clr_bcol(clr_bcol), .clr_irq(clr_irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_rdata(buf_rdata), .buf_full(buf_full),
        .ovf(ovf), .wcol(wcol), .bcol(bcol), .data_flag(data_flag),
        .rw_flag(rw_flag), .ack_stat(ack_stat), .irq(irq)
    );

    function automatic logic exp_match(input logic [7:0] b);
        return b[7:1] == OWN;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        wait_clk(1);
        while (!scl_in) wait_clk(1);
        wait_clk(HALF);
    endtask

    task automatic scl_down();
        m_scl = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;
        wait_clk(2);
        scl_up();
        scl_down();
    endtask

    task automatic get_bit(input logic pull, output logic b);
        m_sda = !pull;
        wait_clk(2);
        m_scl = 1'b1;
        wait_clk(1);
        while (!scl_in) wait_clk(1);
        wait_clk(HALF/2);
        b = sda_in;
        wait_clk(HALF/2);
        scl_down();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(2);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b0; start_pulse = 1'b1; wait_clk(1); start_pulse = 1'b0;
        wait_clk(HALF);
        scl_down();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(2);
        scl_up();
        m_sda = 1'b1; stop_pulse = 1'b1; wait_clk(1); stop_pulse = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(1'b0, a);
        acked = !a;
    endtask

    task automatic recv_byte(input logic give_ack, input int clash_bit, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(clash_bit == i, x);
            b[i] = x;
        end
        put_bit(!give_ack);
    endtask

    task automatic host_read(output logic [7:0] d);
        d = buf_rdata; buf_rd = 1'b1; wait_clk(1); buf_rd = 1'b0;
    endtask
    task automatic host_write(input logic [7:0] d);
        buf_wdata = d; buf_wr = 1'b1; wait_clk(1); buf_wr = 1'b0; wait_clk(1);
    endtask
    task automatic host_release();
        release_wr = 1'b1; wait_clk(1); release_wr = 1'b0;
    endtask
    task automatic host_clr_irq();
        clr_irq = 1'b1; wait_clk(1); clr_irq = 1'b0;
    endtask

    // Write transaction: address then nb random data bytes.
    task automatic do_write(input logic [6:0] addr, input int nb, input logic st);
        logic ack, m;
        logic [7:0] d, got;
        int drv0;
        stretch_en = st;
        m = exp_match({addr, 1'b0});
        drv0 = sda_drv;
        bus_start();
        check("R9 start clears rw", rw_flag, 0);
        send_byte({addr, 1'b0}, ack);
        check("R1 address ack", ack, m);
        if (m) begin
            check("R1 rw latched 0", rw_flag, 0);
            check("R1 buffer holds address", buf_rdata, {addr, 1'b0});
            check("R12 address flag", data_flag, 0);
            check("R4 full after write address", buf_full, 1);
            check("R8 irq after address", irq, 1);
            check("R6 hold follows stretch_en", scl_oe, st);
            host_read(got); host_clr_irq(); host_release();
            check("R4 read clears full", buf_full, 0);
            for (int k = 0; k < nb; k++) begin
                d = 8'($urandom);
                send_byte(d, ack);
                check("R1 data ack", ack, 1);
                check("R4 data byte in buffer", buf_rdata, d);
                check("R12 data flag", data_flag, 1);
                check("R13 irq sticky R8", irq, 1);
                check("R6 hold after data", scl_oe, st);
                host_read(got); host_clr_irq(); host_release();
            end
        end else begin
            for (int k = 0; k < nb; k++) begin
                send_byte(8'($urandom), ack);
                check("R2 data ignored after mismatch", ack, 0);
            end
            check("R2 no irq on mismatch", irq, 0);
            check("R2 sda never driven", sda_drv - drv0, 0);
        end
        bus_stop();
        check("R9 stop frees scl", scl_oe, 0);
    endtask

    // Read transaction: nb bytes, master ACKs all but the last.
    task automatic do_read(input int nb);
        logic ack;
        logic [7:0] d, got;
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        check("R1 read address ack", ack, 1);
        check("R1 rw latched 1", rw_flag, 1);
        check("R5 hold after read address", scl_oe, 1);
        check("R4 read address leaves empty", buf_full, 0);
        host_clr_irq();
        for (int k = 0; k < nb; k++) begin
            d = 8'($urandom);
            host_write(d);
            check("R4 write sets full", buf_full, 1);
            check("R7 first bit on write", sda_oe, !d[7]);
            host_release();
            recv_byte(k < nb - 1, -1, got);
            check("R7 transmitted byte", got, d);
            check("R4 full clears after send", buf_full, 0);
            check("R8 ack status", ack_stat, k == nb - 1);
            check("R8 irq after sent byte", irq, 1);
            check("R12 data flag after send", data_flag, 1);
            if (k < nb - 1) check("R5 hold after acked byte", scl_oe, 1);
            else begin
                check("R9 nack no hold", scl_oe, 0);
                check("R9 nack clears rw", rw_flag, 0);
            end
            host_clr_irq();
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] got, first;
        void'($urandom(32'd20240611));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        check("R4 reset full", buf_full, 0);
        check("R8 reset irq", irq, 0);
        check("R5 reset scl_oe", scl_oe, 0);
        check("R1 reset sda_oe", sda_oe, 0);
        check("R3 reset ovf", ovf, 0);

        // Directed mismatch and basic transfers.
        do_write(OWN ^ 7'h01, 2, 1'b0);
        do_write(OWN, 2, 1'b1);
        do_read(2);

        // R3 overflow: second data byte arrives while first is unread.
        stretch_en = 1'b0;
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        host_read(got); host_clr_irq();
        send_byte(8'hA5, ack);
        check("R3 first byte acked", ack, 1);
        host_clr_irq();
        send_byte(8'h3C, ack);
        check("R3 no ack on full", ack, 0);
        check("R3 buffer unchanged", buf_rdata, 8'hA5);
        check("R3 ovf set", ovf, 1);
        check("R3 no irq on overflow", irq, 0);
        bus_stop();
        host_read(got);
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R3 ovf still blocks", ack, 0);
        bus_stop();
        clr_ovf = 1'b1; wait_clk(1); clr_ovf = 1'b0;
        check("R3 ovf cleared", ovf, 0);
        do_write(OWN, 1, 1'b0);

        // R10 write collision.
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        host_clr_irq();
        host_write(8'h5A);
        host_write(8'hC3);
        check("R10 wcol set", wcol, 1);
        check("R10 buffer kept", buf_rdata, 8'h5A);
        clr_wcol = 1'b1; wait_clk(1); clr_wcol = 1'b0;
        check("R10 wcol cleared", wcol, 0);
        host_release();
        recv_byte(1'b0, -1, got);
        check("R10 first byte sent", got, 8'h5A);
        host_clr_irq();
        bus_stop();

        // R11 bus collision, flag enabled then disabled.
        for (int e = 1; e >= 0; e--) begin
            bcol_en = e[0];
            bus_start();
            send_byte({OWN, 1'b1}, ack);
            host_clr_irq();
            host_write(8'hFF);
            host_release();
            recv_byte(1'b1, 5, got);
            check("R11 clash byte seen", got, 8'hDF);
            check("R11 bcol per enable", bcol, e[0]);
            check("R11 engine stops driving", sda_oe, 0);
            check("R11 no irq after clash", irq, 0);
            bus_stop();
            clr_bcol = 1'b1; wait_clk(1); clr_bcol = 1'b0;
            host_read(first);
        end
        check("R11 bcol cleared", bcol, 0);

        // Constrained random transfers.
        for (int t = 0; t < 16; t++) begin
            logic [6:0] a;
            a = ($urandom % 4 == 0) ? 7'($urandom) : OWN;
            if ($urandom % 2 == 0) do_write(a, 1 + int'($urandom % 3), 1'($urandom));
            else do_read(1 + int'($urandom % 3));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule